// File: doc/BRIEF.md
# Posted-Write Timer Register Bridge

This block connects a fast register bus to the slow functional clock of a timer. Ten timer registers are synchronised: the bus writes them, and a far-side register file in the functional clock domain receives each value through its own toggle handshake. Each of these registers has a pending flag. The flag is set in the bus clock when a write is launched. It clears when the functional side has taken the value and its acknowledgment has come back across a synchroniser.

In posted mode the bus gets its acknowledgment at once, and software polls the pending flag before it touches that register again. A write that lands on a register whose flag is still set is discarded. In non-posted mode the bus ready signal stays low until the transfer has crossed and come back. Four more registers are plain bus-clock registers with no pending flag: a wakeup-enable word, the pending-status vector, an interface-control word and a system status word. A soft reset is started through the interface-control word. It waits for all pending transfers to drain, clears the far side, and then raises a reset-done bit.

Top module: `pwb_bridge`

## Requirements
- R1: The register map is as follows. Addresses 0 to 9 hold the synchronised registers. Address 10 is wakeup-enable. Address 11 is pending status, where bit i is the flag of register i. Address 12 is interface control: bit 2 enables posted mode and bit 1 requests a soft reset. Address 13 is system status, where bit 0 means reset done. After hardware reset, every register reads 0 except system status, which reads 1, and posted mode is off.
- R2: In posted mode, every access is acknowledged in the cycle it is presented. A write to a synchronised register with a clear flag sets that flag from the next cycle until the acknowledgment returns.
- R3: In non-posted mode, a write to a synchronised register holds bus_ready low until the value is present on fn_regs and the register's flag is clear.
- R4: In posted mode, a write to a synchronised register whose flag is still set is acknowledged but discarded. The register and its far-side copy keep the earlier value.
- R5: A read of a synchronised register returns the last value the functional side has taken. In posted mode, a read during a pending write returns the previous value without a stall.
- R6: In non-posted mode, a read of a synchronised register whose flag is set stalls until the flag clears, and then returns the new value.
- R7: Flags of posted writes issued in order to distinct registers clear in that issue order. A flag of an earlier write is never still set once a later write's flag has cleared.
- R8: Wakeup-enable and interface control are written without posting. They read back the written value in the next access and set no pending flag.
- R9: Writing interface control with bit 1 set makes system status read 0. It waits for all flags to clear, then sets all synchronised registers, their far-side copies, wakeup-enable and interface control to 0, with posted mode off. Only then does system status read 1 again. Writes made before completion are ignored.
- R10: fn_regs carries register i in bits [i*DW +: DW], in the functional clock domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| rst_bus_n | input | 1 | Asynchronous active-low reset, bus domain |
| clk_fn | input | 1 | Timer functional clock |
| rst_fn_n | input | 1 | Asynchronous active-low reset, functional domain |
| bus_sel | input | 1 | Access request, held until bus_ready |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW (4) | Register address |
| bus_wdata | input | DW (16) | Write data |
| bus_ready | output | 1 | Access completes in this cycle |
| bus_rdata | output | DW (16) | Read data, valid with bus_ready |
| fn_regs | output | NSYNC*DW (160) | Far-side copies of the synchronised registers |

## Verification
The bench drives a second write into a register that is still pending. A design that let that write through would show the later value on readback. It reads a register during a pending posted write: a design that returned the in-flight value, or stalled, would fail R5. It then turns posted mode off with a write still in flight. A non-posted read that did not stall would return stale data. A sweep of posted writes across all ten registers is polled repeatedly for out-of-order flag clearing. A soft reset issued with a transfer in flight is checked for a premature done bit and for a write made during the reset that leaks through.

// File: rtl/pwb_pkg.sv
`timescale 1ns/1ps
package pwb_pkg;
   localparam int unsigned SYNC_REG_COUNT = 10;
   localparam int unsigned IFC_SRST_BIT   = 1;
   localparam int unsigned IFC_POSTED_BIT = 2;

   typedef enum logic [0:0] {B_IDLE, B_WAIT} bus_st_e;
   typedef enum logic [1:0] {SR_IDLE, SR_DRAIN, SR_WAIT} srst_st_e;
endpackage

// File: rtl/pwb_sync.sv
`timescale 1ns/1ps
module pwb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pwb_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pwb_chan.sv
`timescale 1ns/1ps
module pwb_chan #(
   parameter int DW     = 16,
   parameter int STAGES = 2
) (
   input  logic          clk_b,
   input  logic          rst_b_n,
   input  logic          launch,
   input  logic [DW-1:0] wdata,
   input  logic          shadow_clr,
   output logic          pend,
   output logic [DW-1:0] shadow,
   input  logic          clk_f,
   input  logic          rst_f_n,
   input  logic          fn_clr,
   output logic [DW-1:0] fn_q,
   output logic          fn_take
);
   logic          req_t, req_s, req_seen;
   logic          ack_t, ack_s, ack_seen, ack_edge;
   logic [DW-1:0] hold_q;

   // bus side: launch, hold, await acknowledgment
   assign ack_edge = ack_s ^ ack_seen;

   always_ff @(posedge clk_b or negedge rst_b_n) begin
      if (!rst_b_n) begin
         req_t    <= 1'b0;
         pend     <= 1'b0;
         hold_q   <= '0;
         shadow   <= '0;
         ack_seen <= 1'b0;
      end else begin
         if (launch) begin
            hold_q <= wdata;
            req_t  <= ~req_t;
            pend   <= 1'b1;
         end
         if (ack_edge) begin
            ack_seen <= ack_s;
            pend     <= 1'b0;
            shadow   <= hold_q;
         end else if (shadow_clr) begin
            shadow <= '0;
         end
      end
   end

   pwb_sync #(.STAGES(STAGES)) u_req_sync (
      .clk(clk_f), .rst_n(rst_f_n), .d(req_t), .q(req_s));

   // functional side: take held value, return toggle
   assign fn_take = req_s ^ req_seen;

   always_ff @(posedge clk_f or negedge rst_f_n) begin
      if (!rst_f_n) begin
         req_seen <= 1'b0;
         ack_t    <= 1'b0;
         fn_q     <= '0;
      end else if (fn_take) begin
         req_seen <= req_s;
         ack_t    <= ~ack_t;
         fn_q     <= hold_q;
      end else if (fn_clr) begin
         fn_q <= '0;
      end
   end

   pwb_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk(clk_b), .rst_n(rst_b_n), .d(ack_t), .q(ack_s));

   AST_NO_RELAUNCH: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      launch |-> !pend);  // R4
   AST_ACK_NEEDS_PEND: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      ack_edge |-> pend);  // R2
   AST_HOLD_WHILE_PEND: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      (pend && !launch) |=> $stable(hold_q));  // R4
endmodule

// File: rtl/pwb_bridge.sv
`timescale 1ns/1ps
module pwb_bridge
   import pwb_pkg::*;
#(
   parameter  int DW     = 16,
   parameter  int NSYNC  = SYNC_REG_COUNT,
   parameter  int STAGES = 2,
   localparam int AW     = $clog2(NSYNC + 4)
) (
   input  logic                clk_bus,
   input  logic                rst_bus_n,
   input  logic                clk_fn,
   input  logic                rst_fn_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [AW-1:0]       bus_addr,
   input  logic [DW-1:0]       bus_wdata,
   output logic                bus_ready,
   output logic [DW-1:0]       bus_rdata,
   output logic [NSYNC*DW-1:0] fn_regs
);
   localparam int A_WAKE = NSYNC;
   localparam int A_PEND = NSYNC + 1;
   localparam int A_IFC  = NSYNC + 2;
   localparam int A_STAT = NSYNC + 3;
   localparam int IW     = (NSYNC > 1) ? $clog2(NSYNC) : 1;

   generate
      if (NSYNC < 1) begin : g_bad_nsync
         $error("pwb_bridge: NSYNC must be at least 1");
      end
      if (DW < NSYNC || DW < 3) begin : g_bad_dw
         $error("pwb_bridge: DW must cover the pending vector and control bits");
      end
   endgenerate

   logic [NSYNC-1:0] pend, launch, took;
   logic [DW-1:0]    shadow [NSYNC];
   logic             is_sync, pend_sel, acc_plain, busy_rst;
   logic [IW-1:0]    idx;
   bus_st_e          bst, bst_nx;
   srst_st_e         sst;
   logic             posted_q, done_q;
   logic [DW-1:0]    wake_q;
   logic             rst_launch, rst_pend, fn_wipe, shadow_clr;
   logic [0:0]       srst_shadow, srst_fnq;

   assign is_sync  = int'(bus_addr) < NSYNC;
   assign idx      = bus_addr[IW-1:0];
   assign pend_sel = is_sync && pend[idx];
   assign busy_rst = (sst != SR_IDLE);

   // access sequencing
   always_comb begin
      bus_ready = 1'b0;
      launch    = '0;
      bst_nx    = bst;
      acc_plain = 1'b0;
      if (bst == B_WAIT) begin
         bus_ready = !pend_sel;
         if (!pend_sel) bst_nx = B_IDLE;
      end else if (bus_sel) begin
         if (is_sync && bus_wr && !busy_rst) begin
            if (posted_q) begin
               bus_ready = 1'b1;
               if (!pend_sel) launch[idx] = 1'b1;
            end else if (!pend_sel) begin
               launch[idx] = 1'b1;
               bst_nx      = B_WAIT;
            end
         end else if (is_sync && !bus_wr && !posted_q) begin
            bus_ready = !pend_sel;
         end else begin
            bus_ready = 1'b1;
            acc_plain = bus_wr && !is_sync && !busy_rst;
         end
      end
   end

   // soft-reset sequencing
   always_comb begin
      rst_launch = (sst == SR_DRAIN) && (pend == '0);
      shadow_clr = (sst == SR_WAIT) && !rst_pend && srst_shadow[0];
   end

   always_ff @(posedge clk_bus or negedge rst_bus_n) begin
      if (!rst_bus_n) begin
         bst      <= B_IDLE;
         sst      <= SR_IDLE;
         posted_q <= 1'b0;
         done_q   <= 1'b1;
         wake_q   <= '0;
      end else begin
         bst <= bst_nx;
         if (acc_plain) begin
            if (int'(bus_addr) == A_WAKE) begin
               wake_q <= bus_wdata;
            end else if (int'(bus_addr) == A_IFC) begin
               if (bus_wdata[IFC_SRST_BIT]) begin
                  posted_q <= 1'b0;
                  wake_q   <= '0;
                  done_q   <= 1'b0;
                  sst      <= SR_DRAIN;
               end else begin
                  posted_q <= bus_wdata[IFC_POSTED_BIT];
               end
            end
         end
         if (rst_launch) sst <= SR_WAIT;
         if (shadow_clr) begin
            sst    <= SR_IDLE;
            done_q <= 1'b1;
         end
      end
   end

   // register channels
   generate
      for (genvar g = 0; g < NSYNC; g++) begin : g_ch
         pwb_chan #(.DW(DW), .STAGES(STAGES)) u_ch (
            .clk_b(clk_bus), .rst_b_n(rst_bus_n),
            .launch(launch[g]), .wdata(bus_wdata), .shadow_clr(shadow_clr),
            .pend(pend[g]), .shadow(shadow[g]),
            .clk_f(clk_fn), .rst_f_n(rst_fn_n), .fn_clr(fn_wipe),
            .fn_q(fn_regs[g*DW +: DW]), .fn_take(took[g]));
      end
   endgenerate

   pwb_chan #(.DW(1), .STAGES(STAGES)) u_srst (
      .clk_b(clk_bus), .rst_b_n(rst_bus_n),
      .launch(rst_launch), .wdata(1'b1), .shadow_clr(1'b0),
      .pend(rst_pend), .shadow(srst_shadow),
      .clk_f(clk_fn), .rst_f_n(rst_fn_n), .fn_clr(1'b0),
      .fn_q(srst_fnq), .fn_take(fn_wipe));

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (is_sync)                        bus_rdata = shadow[idx];
      else if (int'(bus_addr) == A_WAKE)  bus_rdata = wake_q;
      else if (int'(bus_addr) == A_PEND)  bus_rdata = DW'(pend);
      else if (int'(bus_addr) == A_IFC)   bus_rdata[IFC_POSTED_BIT] = posted_q;
      else if (int'(bus_addr) == A_STAT)  bus_rdata[0] = done_q;
   end

   AST_POSTED_NO_STALL: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
      (bus_sel && posted_q && bst == B_IDLE) |-> bus_ready);  // R2
   AST_POSTED_MARKS: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
      (bus_sel && bus_wr && is_sync && posted_q && !busy_rst && !pend_sel)
      |=> pend[$past(idx)]);  // R2
   AST_NP_WR_WAITS: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
      (bus_sel && bus_wr && is_sync && !posted_q && !busy_rst && bus_ready) |-> !pend_sel);  // R3
   AST_NP_RD_WAITS: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
      (bus_sel && !bus_wr && is_sync && !posted_q && bus_ready) |-> !pend_sel);  // R6
   AST_DONE_LOW_BUSY: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
      busy_rst |-> !done_q);  // R9
   AST_DRAINED: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
      $rose(done_q) |-> (pend == '0));  // R9
   AST_WIPE_ALONE: assert property (@(posedge clk_fn) disable iff (!rst_fn_n)
      fn_wipe |-> (took == '0));  // R9
   AST_WIPE_FLAG: assert property (@(posedge clk_fn) disable iff (!rst_fn_n)
      fn_wipe |=> srst_fnq[0]);  // R9
endmodule

// File: tb/sim_pwb_bridge.sv
`timescale 1ns/1ps
module sim_pwb_bridge;
   localparam int DW = 16;
   localparam int N  = 10;
   localparam int AW = 4;
   localparam int A_WAKE = 10, A_PEND = 11, A_IFC = 12, A_STAT = 13;

   logic clk_bus = 1'b0, clk_fn = 1'b0;
   logic rst_bus_n = 1'b0, rst_fn_n = 1'b0;
   logic bus_sel = 1'b0, bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic bus_ready;
   logic [DW-1:0] bus_rdata;
   logic [N*DW-1:0] fn_regs;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #10 clk_bus = ~clk_bus;   // 50 MHz
   always #50 clk_fn  = ~clk_fn;    // five times slower

   pwb_bridge #(.DW(DW), .NSYNC(N), .STAGES(2)) u0 (
      .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .clk_fn(clk_fn), .rst_fn_n(rst_fn_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ready(bus_ready), .bus_rdata(bus_rdata), .fn_regs(fn_regs));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
   endtask

   task automatic xfer(input bit wr, input int addr, input logic [DW-1:0] wd,
                       output logic [DW-1:0] rd, output int waits);
      @(negedge clk_bus);
      bus_sel = 1'b1; bus_wr = wr; bus_addr = AW'(addr); bus_wdata = wd;
      waits = 0; rd = '0;
      forever begin
         #1;
         if (bus_ready) begin
            rd = bus_rdata;
            @(posedge clk_bus);
            break;
         end
         waits++;
         @(negedge clk_bus);
      end
      #1 bus_sel = 1'b0;
   endtask

   task automatic wr(input int addr, input logic [DW-1:0] d, output int waits);
      logic [DW-1:0] dummy;
      xfer(1'b1, addr, d, dummy, waits);
   endtask

   task automatic rd(input int addr, output logic [DW-1:0] d, output int waits);
      xfer(1'b0, addr, '0, d, waits);
   endtask

   task automatic wait_pend_bit(input int b);
      logic [DW-1:0] p;
      int w;
      for (int k = 0; k < 500; k++) begin
         rd(A_PEND, p, w);
         if (!p[b]) break;
      end
   endtask

   function automatic logic [DW-1:0] pat(input int i);
      return 16'h1000 + 16'(i) * 16'h0111;
   endfunction

   initial begin
      logic [DW-1:0] d, p;
      int w;
      bit first_nz, mono;
      repeat (5) @(posedge clk_fn);
      rst_bus_n = 1'b1; rst_fn_n = 1'b1;
      repeat (3) @(posedge clk_bus);

      // R1 reset state
      rd(A_PEND, d, w); chk("R1 pend after reset", d, 0);
      rd(A_IFC, d, w);  chk("R1 ifctl after reset", d, 0);
      rd(A_STAT, d, w); chk("R1 status after reset", d, 1);
      rd(A_WAKE, d, w); chk("R1 wake after reset", d, 0);
      for (int i = 0; i < N; i++) begin
         rd(i, d, w); chk("R1 reg after reset", d, 0);
      end

      // R3 non-posted write stalls until the far side holds the value
      wr(4, 16'h1234, w);
      chk("R3 non-posted write stalled", (w >= 3), 1);
      chk("R3 far side after completion", fn_regs[4*DW +: DW], 16'h1234);
      rd(A_PEND, d, w); chk("R3 pend clear", d, 0);
      rd(4, d, w); chk("R5 readback committed", d, 16'h1234);

      // R8 wakeup-enable, no pending flag
      wr(A_WAKE, 16'h00A5, w); chk("R8 wake write no stall", w, 0);
      rd(A_PEND, d, w); chk("R8 no pend flag", d, 0);
      rd(A_WAKE, d, w); chk("R8 wake readback", d, 16'h00A5);

      // enable posted mode
      wr(A_IFC, 16'h0004, w);
      rd(A_IFC, d, w); chk("R8 ifctl readback", d, 16'h0004);

      // R2 / R5 single posted write
      wr(7, 16'h7777, w); chk("R2 posted write immediate", w, 0);
      chk("R2 far side not yet updated", fn_regs[7*DW +: DW], 0);
      rd(A_PEND, d, w); chk("R2 pend bit 7 set", d, 16'h0080);
      rd(7, d, w); chk("R5 read during pending no stall", w, 0);
      chk("R5 read during pending returns old", d, 0);
      wait_pend_bit(7);
      rd(7, d, w); chk("R5 polled readback", d, 16'h7777);
      chk("R10 far side reg7", fn_regs[7*DW +: DW], 16'h7777);

      // R7 sweep of posted writes in order
      for (int i = 0; i < N; i++) begin
         wr(i, pat(i), w); chk("R2 sweep write immediate", w, 0);
      end
      first_nz = 1'b0;
      for (int k = 0; k < 500; k++) begin
         rd(A_PEND, p, w);
         if (k == 0) first_nz = (p != 0);
         mono = 1'b1;
         for (int i = 0; i < N; i++)
            for (int j = i + 1; j < N; j++)
               if (p[i] && !p[j]) mono = 1'b0;
         chk("R7 pend clears in issue order", mono, 1);
         if (p == 0) break;
      end
      chk("R7 last write still pending at first poll", first_nz, 1);
      for (int i = 0; i < N; i++) begin
         rd(i, d, w); chk("R5 sweep readback", d, pat(i));
         chk("R10 sweep far side", fn_regs[i*DW +: DW], pat(i));
      end

      // R4 write to a pending register is lost
      wr(3, 16'hAAAA, w);
      wr(3, 16'h5555, w); chk("R4 lost write still acknowledged", w, 0);
      wait_pend_bit(3);
      rd(3, d, w); chk("R4 register keeps first value", d, 16'hAAAA);
      chk("R4 far side keeps first value", fn_regs[3*DW +: DW], 16'hAAAA);

      // R6 non-posted read waits for a pending flag
      wr(5, 16'hC0DE, w);
      wr(A_IFC, 16'h0000, w);
      rd(5, d, w);
      chk("R6 non-posted read stalled", (w >= 1), 1);
      chk("R6 non-posted read value", d, 16'hC0DE);

      // R9 soft reset with a write in flight
      wr(A_IFC, 16'h0004, w);
      wr(2, 16'h2222, w);
      wr(A_IFC, 16'h0006, w);
      rd(A_STAT, d, w); chk("R9 status low during reset", d, 0);
      wr(2, 16'hBEEF, w);
      for (int k = 0; k < 500; k++) begin
         rd(A_STAT, d, w);
         if (d[0]) break;
      end
      chk("R9 status done", d, 1);
      rd(A_IFC, d, w);  chk("R9 posted off", d, 0);
      rd(A_WAKE, d, w); chk("R9 wake cleared", d, 0);
      rd(A_PEND, d, w); chk("R9 pend clear", d, 0);
      for (int i = 0; i < N; i++) begin
         rd(i, d, w); chk("R9 reg cleared", d, 0);
         chk("R9 far side cleared", fn_regs[i*DW +: DW], 0);
      end

      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk_bus);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         summary();
         $finish;
      end
   end
endmodule